// File: doc/BRIEF.md
# Delta-Matching Stride Prefetch Generator

This block sits beside a cache miss path. It watches demand-miss addresses and, for each requester, remembers the block addresses of its two most recent misses. When the distance from the previous miss to the current one equals the distance between the two misses before it, the stream is taken to be strided. The block then produces a short burst of candidate prefetch addresses that continue that stride.

Candidates leave one per cycle. Each carries the same configured delay value. A burst can be cut short where a candidate would leave the virtual page of the triggering miss, and the block keeps a running total of the candidates lost that way. History can be private to each requester or shared by all of them. Queueing, filtering and deduplication of the candidates belong to the consumer.

Top module: `stride_pf_gen`

## Requirements
- R1: The miss address is reduced to its block address by clearing its low log2(BLK_BYTES) bits before any arithmetic. Every emitted candidate therefore has those bits at zero.
- R2: An accepted miss shifts its history slot: the older entry takes the previous newest value, and the newest entry takes the current block address. With `cfg_per_req`=1 the slot is `miss_id`. With `cfg_per_req`=0 every requester uses slot 0.
- R3: When the new delta (block minus newest entry) equals the old delta (newest entry minus older entry), the block emits candidates block + d*delta for d = 1 up to `cfg_degree`, in increasing d. They appear on consecutive cycles, with the first one in the cycle after the accepting clock edge.
- R4: When the two deltas differ, no candidate is emitted and `busy` stays low.
- R5: With `cfg_page_stop`=1, a candidate whose address bits above log2(PAGE_BYTES) differ from those of the triggering block is not emitted, and the burst ends there. With `cfg_page_stop`=0, page crossings do not stop emission.
- R6: When a burst is cut at step d, `span_cnt` grows by `cfg_degree` - d + 1. It is updated at the clock edge where `busy` falls and is unchanged at every other edge.
- R7: Every candidate of a burst carries on `pf_delay` the `cfg_latency` value sampled when the miss was accepted.
- R8: `busy` is high from the cycle after an accepted miss until the last cycle of its burst, including a final cycle spent detecting a page crossing. `pf_vld` is never high while `busy` is low. A miss presented while `busy` is high is ignored and does not touch the history.
- R9: After reset, all history entries are zero and `pf_vld`, `busy` and `span_cnt` are zero.
- R10: Deltas are treated as two's-complement values, so descending streams are detected and continued downward.
- R11: With `cfg_degree`=0, a matching miss updates history but produces no burst and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_vld | input | 1 | A demand miss is presented this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_id | input | ID_W | Requester that missed |
| cfg_per_req | input | 1 | 1: history per requester, 0: one shared history |
| cfg_page_stop | input | 1 | 1: end a burst at a page crossing |
| cfg_degree | input | DEG_W | Number of candidates per burst |
| cfg_latency | input | LAT_W | Delay value attached to every candidate |
| pf_vld | output | 1 | Candidate present on `pf_addr` |
| pf_addr | output | ADDR_W | Candidate block address |
| pf_delay | output | LAT_W | Delay carried by the candidate |
| busy | output | 1 | A burst is in progress; new misses are ignored |
| span_cnt | output | SPAN_W | Running count of candidates dropped at page crossings |

## Verification
Two things can coincide. In the same cycle, a miss arrives while a burst from an earlier miss is still running, and detection for the new miss would have to run alongside that emission. The bench causes this by presenting an unrelated miss during the first cycle of a burst. It then judges the outcome from later misses on the same requester: the candidates they produce must match a model whose history never saw the intruder. Truncation and burst completion can also fall on the same edge, with a page crossing at the last degree step. The sweep over strides, degrees and page-stop settings hits this case, and the check is that both `busy` length and `span_cnt` agree with the arithmetic expectation.

// File: rtl/stride_pf_pkg.sv
// Shared definitions for the stride prefetch generator.
// Assumes nothing beyond the mode encoding being a single bit.
package stride_pf_pkg;

    // History sharing mode, matches the cfg_per_req bit.
    typedef enum logic {
        HIST_SHARED  = 1'b0,
        HIST_PER_REQ = 1'b1
    } hist_mode_e;

endpackage

// File: rtl/stride_pf_hist.sv
// Per-requester miss history: two block addresses per slot.
// Assumes requester IDs below REQ_N; an out-of-range ID writes no slot
// and reads zeros.
module stride_pf_hist #(
    parameter int ADDR_W = 32,
    parameter int REQ_N  = 4,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   slot,
    input  logic [ADDR_W-1:0] blk_addr,
    output logic [ADDR_W-1:0] newest,
    output logic [ADDR_W-1:0] older
);
    logic [ADDR_W-1:0] newest_q [REQ_N];
    logic [ADDR_W-1:0] older_q  [REQ_N];

    // Shift the selected slot on every accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REQ_N; i++) begin
                newest_q[i] <= '0;
                older_q[i]  <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < REQ_N; i++) begin
                if (slot == ID_W'(i)) begin
                    older_q[i]  <= newest_q[i];
                    newest_q[i] <= blk_addr;
                end
            end
        end
    end

    // Read the selected slot.
    always_comb begin
        newest = '0;
        older  = '0;
        for (int i = 0; i < REQ_N; i++) begin
            if (slot == ID_W'(i)) begin
                newest = newest_q[i];
                older  = older_q[i];
            end
        end
    end
endmodule

// File: rtl/stride_pf_detect.sv
// Delta comparator: finds a repeated stride from three block addresses.
// Deltas wrap modulo 2**ADDR_W, so equality also holds for negative strides.
module stride_pf_detect #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_blk,
    input  logic [ADDR_W-1:0] newest,
    input  logic [ADDR_W-1:0] older,
    output logic              match,
    output logic [ADDR_W-1:0] stride
);
    logic [ADDR_W-1:0] delta_new;
    logic [ADDR_W-1:0] delta_old;

    // Two's-complement differences and their comparison.
    always_comb begin
        delta_new = cur_blk - newest;
        delta_old = newest - older;
        match     = (delta_new == delta_old);
        stride    = delta_new;
    end
endmodule

// File: rtl/stride_pf_emit.sv
// Burst emitter: walks base+stride, base+2*stride, ... one step per cycle.
// Assumes start is only raised while idle. Stops early on a page crossing
// when enabled and adds the unemitted count to the span counter.
module stride_pf_emit #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int DEG_W     = 3,
    parameter int LAT_W     = 8,
    parameter int SPAN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [DEG_W-1:0]  degree,
    input  logic [LAT_W-1:0]  latency,
    input  logic              page_stop,
    output logic              pf_vld,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [LAT_W-1:0]  pf_delay,
    output logic              busy,
    output logic [SPAN_W-1:0] span_cnt
);
    localparam int PG_W = ADDR_W - PAGE_BITS;

    logic              active_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] stride_q;
    logic [PG_W-1:0]   page_q;
    logic [DEG_W-1:0]  idx_q;
    logic [DEG_W-1:0]  deg_q;
    logic              stop_q;
    logic [LAT_W-1:0]  lat_q;
    logic [SPAN_W-1:0] span_q;
    logic              crossing;
    logic [DEG_W:0]    left;

    // Page comparison and count of steps not yet emitted.
    always_comb begin
        crossing = stop_q && (cur_q[ADDR_W-1:PAGE_BITS] != page_q);
        left     = {1'b0, deg_q} - {1'b0, idx_q} + (DEG_W+1)'(1);
    end

    // Burst sequencing and span accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            stride_q <= '0;
            page_q   <= '0;
            idx_q    <= '0;
            deg_q    <= '0;
            stop_q   <= 1'b0;
            lat_q    <= '0;
            span_q   <= '0;
        end else if (!active_q) begin
            if (start && degree != '0) begin
                active_q <= 1'b1;
                cur_q    <= base + stride;
                stride_q <= stride;
                page_q   <= base[ADDR_W-1:PAGE_BITS];
                idx_q    <= DEG_W'(1);
                deg_q    <= degree;
                stop_q   <= page_stop;
                lat_q    <= latency;
            end
        end else if (crossing) begin
            active_q <= 1'b0;
            span_q   <= span_q + SPAN_W'(left);
        end else if (idx_q == deg_q) begin
            active_q <= 1'b0;
        end else begin
            idx_q <= idx_q + DEG_W'(1);
            cur_q <= cur_q + stride_q;
        end
    end

    assign pf_vld   = active_q && !crossing;
    assign pf_addr  = cur_q;
    assign pf_delay = lat_q;
    assign busy     = active_q;
    assign span_cnt = span_q;
endmodule

// File: rtl/stride_pf_gen.sv
// Stride prefetch generator top: aligns misses, keeps history, detects a
// repeated delta and launches a candidate burst. Assumes BLK_BYTES and
// PAGE_BYTES are powers of two with 2 <= BLK_BYTES <= PAGE_BYTES < 2**ADDR_W.
module stride_pf_gen #(
    parameter int ADDR_W     = 32,
    parameter int BLK_BYTES  = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int REQ_N      = 4,
    parameter int DEG_W      = 3,
    parameter int LAT_W      = 8,
    parameter int SPAN_W     = 16,
    parameter int ID_W       = (REQ_N > 1) ? $clog2(REQ_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_vld,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [ID_W-1:0]   miss_id,
    input  logic              cfg_per_req,
    input  logic              cfg_page_stop,
    input  logic [DEG_W-1:0]  cfg_degree,
    input  logic [LAT_W-1:0]  cfg_latency,
    output logic              pf_vld,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [LAT_W-1:0]  pf_delay,
    output logic              busy,
    output logic [SPAN_W-1:0] span_cnt
);
    import stride_pf_pkg::*;

    localparam int BLK_BITS  = $clog2(BLK_BYTES);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] blk;
    logic [ID_W-1:0]   slot;
    logic              accept;
    logic [ADDR_W-1:0] h_newest;
    logic [ADDR_W-1:0] h_older;
    logic              match;
    logic [ADDR_W-1:0] stride;
    hist_mode_e        mode;

    // Block alignment and acceptance (misses during a burst are dropped).
    always_comb begin
        blk    = {miss_addr[ADDR_W-1:BLK_BITS], BLK_BITS'(0)};
        accept = miss_vld && !busy;
        mode   = hist_mode_e'(cfg_per_req);
    end

    // Slot selection; a single-slot build always uses slot 0.
    generate
        if (REQ_N > 1) begin : g_multi
            always_comb slot = (mode == HIST_PER_REQ) ? miss_id : '0;
        end else begin : g_single
            always_comb slot = '0;
        end
    endgenerate

    stride_pf_hist #(
        .ADDR_W (ADDR_W),
        .REQ_N  (REQ_N),
        .ID_W   (ID_W)
    ) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .slot     (slot),
        .blk_addr (blk),
        .newest   (h_newest),
        .older    (h_older)
    );

    stride_pf_detect #(
        .ADDR_W (ADDR_W)
    ) det_i (
        .cur_blk (blk),
        .newest  (h_newest),
        .older   (h_older),
        .match   (match),
        .stride  (stride)
    );

    stride_pf_emit #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .DEG_W     (DEG_W),
        .LAT_W     (LAT_W),
        .SPAN_W    (SPAN_W)
    ) emit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && match),
        .base      (blk),
        .stride    (stride),
        .degree    (cfg_degree),
        .latency   (cfg_latency),
        .page_stop (cfg_page_stop),
        .pf_vld    (pf_vld),
        .pf_addr   (pf_addr),
        .pf_delay  (pf_delay),
        .busy      (busy),
        .span_cnt  (span_cnt)
    );
endmodule

// File: rtl/stride_pf_gen_chk.sv
// Temporal checks on the stride prefetch generator's ports.
module stride_pf_gen_chk #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BITS  = 6,
    parameter int DEG_W     = 3,
    parameter int LAT_W     = 8,
    parameter int SPAN_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_vld,
    input logic [DEG_W-1:0]  cfg_degree,
    input logic              pf_vld,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [LAT_W-1:0]  pf_delay,
    input logic              busy,
    input logic [SPAN_W-1:0] span_cnt
);
    // R1
    blk_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_vld |-> pf_addr[BLK_BITS-1:0] == '0);

    // R8
    vld_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_vld |-> busy);

    // R6
    span_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(span_cnt) |-> $fell(busy));

    // R7
    delay_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(pf_delay));

    // R11
    zero_degree_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_vld && !busy && cfg_degree == '0 |=> !busy);
endmodule

bind stride_pf_gen stride_pf_gen_chk #(
    .ADDR_W   (ADDR_W),
    .BLK_BITS ($clog2(BLK_BYTES)),
    .DEG_W    (DEG_W),
    .LAT_W    (LAT_W),
    .SPAN_W   (SPAN_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_vld   (miss_vld),
    .cfg_degree (cfg_degree),
    .pf_vld     (pf_vld),
    .pf_addr    (pf_addr),
    .pf_delay   (pf_delay),
    .busy       (busy),
    .span_cnt   (span_cnt)
);

// File: tb/stride_pf_gen_tb.sv
// Sweep bench: 16-bit addresses, 16-byte blocks, 256-byte pages, 4 requesters.
module stride_pf_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_vld = 1'b0;
    logic [15:0] miss_addr = '0;
    logic [1:0]  miss_id = '0;
    logic        cfg_per_req = 1'b0;
    logic        cfg_page_stop = 1'b0;
    logic [2:0]  cfg_degree = '0;
    logic [7:0]  cfg_latency = '0;
    logic        pf_vld;
    logic [15:0] pf_addr;
    logic [7:0]  pf_delay;
    logic        busy;
    logic [15:0] span_cnt;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_new [4];
    logic [15:0] m_old [4];
    int m_span = 0;

    always #10 clk = ~clk;

    stride_pf_gen #(
        .ADDR_W(16), .BLK_BYTES(16), .PAGE_BYTES(256), .REQ_N(4),
        .DEG_W(3), .LAT_W(8), .SPAN_W(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_addr(miss_addr),
        .miss_id(miss_id), .cfg_per_req(cfg_per_req), .cfg_page_stop(cfg_page_stop),
        .cfg_degree(cfg_degree), .cfg_latency(cfg_latency), .pf_vld(pf_vld),
        .pf_addr(pf_addr), .pf_delay(pf_delay), .busy(busy), .span_cnt(span_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One miss: model expectation, drive, collect the burst, compare.
    task automatic do_miss(input int id, input logic [15:0] addr, input bit inject);
        logic [15:0] blk, nd, od, c;
        logic [15:0] exp_a [8];
        logic [15:0] got_a [16];
        logic [7:0]  got_d [16];
        int exp_n, got_n, bcyc, exp_cyc, slot, deg;
        bit trunc, hit;
        string tag;
        slot  = cfg_per_req ? id : 0;
        deg   = int'(cfg_degree);
        blk   = addr & 16'hFFF0;
        nd    = blk - m_new[slot];
        od    = m_new[slot] - m_old[slot];
        m_old[slot] = m_new[slot];
        m_new[slot] = blk;
        hit   = (nd == od);
        exp_n = 0;
        trunc = 0;
        if (hit) begin
            for (int d = 1; d <= deg; d++) begin
                c = blk + 16'(d) * nd;
                if (cfg_page_stop && c[15:8] != blk[15:8]) begin
                    m_span += deg - d + 1;
                    trunc = 1;
                    break;
                end
                exp_a[exp_n] = c;
                exp_n++;
            end
        end
        exp_cyc = (hit && deg > 0) ? exp_n + int'(trunc) : 0;

        @(negedge clk);
        miss_vld = 1'b1; miss_addr = addr; miss_id = 2'(id);
        @(negedge clk);
        miss_vld = 1'b0;
        got_n = 0; bcyc = 0;
        while (busy && bcyc < 32) begin
            bcyc++;
            if (pf_vld && got_n < 16) begin
                got_a[got_n] = pf_addr;
                got_d[got_n] = pf_delay;
                got_n++;
            end
            if (inject && bcyc == 1) begin
                miss_vld = 1'b1; miss_addr = 16'h7775; miss_id = 2'(id);
            end else begin
                miss_vld = 1'b0;
            end
            @(negedge clk);
        end
        miss_vld = 1'b0;

        tag = (deg == 0) ? "R11" : (!hit ? "R4" : "R3");
        chk(got_n == exp_n, {tag, " candidate count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            // R5: truncated bursts must never show an out-of-page address
            chk(got_a[i] == exp_a[i], nd[15] ? "R10 descending addr" : "R3 R5 addr",
                int'(got_a[i]), int'(exp_a[i]));
            chk(got_a[i][3:0] == 4'h0, "R1 alignment", int'(got_a[i][3:0]), 0);
            chk(got_d[i] == cfg_latency, "R7 delay", int'(got_d[i]), int'(cfg_latency));
        end
        chk(bcyc == exp_cyc, "R8 busy length", bcyc, exp_cyc);
        chk(int'(span_cnt) == m_span, "R5 R6 span count", int'(span_cnt), m_span);
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int strides [6] = '{1, 2, 3, -1, -2, 0};
        for (int i = 0; i < 4; i++) begin m_new[i] = '0; m_old[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports
        chk(pf_vld == 1'b0, "R9 pf_vld", int'(pf_vld), 0);
        chk(busy == 1'b0, "R9 busy", int'(busy), 0);
        chk(span_cnt == 16'h0, "R9 span", int'(span_cnt), 0);
        // R9: zero history makes a miss at block 0 a zero-stride match
        cfg_degree = 3'd2; cfg_latency = 8'h11;
        do_miss(0, 16'h0007, 1'b0);

        // Shared-history sweep over page stop, degree and stride (R10 for negatives).
        for (int ps = 0; ps < 2; ps++) begin
            for (int dg = 0; dg < 6; dg++) begin
                for (int si = 0; si < 6; si++) begin
                    cfg_per_req   = 1'b0;
                    cfg_page_stop = ps[0];
                    cfg_degree    = 3'(dg);
                    cfg_latency   = 8'(dg * 7 + si + ps * 40);
                    for (int k = 0; k < 4; k++)
                        do_miss(si % 4, 16'(16'h0340 + dg * 16 + k * strides[si] * 16 + 5), 1'b0);
                end
            end
        end

        // R2: two interleaved streams, private history then shared history.
        for (int pr = 1; pr >= 0; pr--) begin
            cfg_per_req = pr[0]; cfg_page_stop = 1'b1; cfg_degree = 3'd3; cfg_latency = 8'h2A;
            for (int k = 0; k < 4; k++) begin
                do_miss(0, 16'(16'h1000 + k * 32 + 3), 1'b0);
                do_miss(1, 16'(16'h28F0 - k * 48 + 9), 1'b0);
            end
        end

        // R8: a miss presented during a burst must leave history untouched.
        cfg_per_req = 1'b1; cfg_page_stop = 1'b0; cfg_degree = 3'd4; cfg_latency = 8'h5C;
        for (int k = 0; k < 5; k++)
            do_miss(2, 16'(16'h4400 + k * 16), 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule